// File: doc/BRIEF.md
# Effective Address Generator

This block computes the 32-bit offset of a memory operand from its addressing components and picks the segment the access falls in by default. A caller presents an optional base register (its value and its register number), an optional index register (value and number), a two-bit scale code, a displacement with a two-bit size code, and a flag that selects direct addressing. One strobe on `in_valid` loads the operands. One cycle later the block presents the offset, a flag that is high when the stack segment is the default, and an error flag. The error flag is raised when the stack pointer has been named as the index.

The result stays on the outputs until the next strobe. The control is a two-state machine. In state `ST_EMPTY` no fresh result is present, and `out_valid` is low. In state `ST_LOADED` a result was captured on the previous edge, and `out_valid` is high. There are three transitions:

- `EMPTY->LOADED` is taken on a strobe.
- `LOADED->LOADED` is taken on back-to-back strobes.
- `LOADED->EMPTY` is taken when no strobe arrives.

Register numbers follow the general-register encoding: number 4 is the stack pointer and number 5 is the frame pointer.

Top module: `ea_gen`

## Requirements
- R1: After reset, `out_valid`, `offset`, `seg_stack` and `idx_err` are all 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1, and 0 otherwise. The outputs in that cycle reflect the operands sampled with the strobe.
- R3: When `in_valid` is 0, `offset`, `seg_stack` and `idx_err` keep their previous values, whatever the other inputs do.
- R4: `disp_sz` decodes as follows: 0 means no displacement (0), 1 means `disp[7:0]` sign-extended, 2 means `disp[15:0]` zero-extended, and 3 means all 32 bits of `disp`.
- R5: With `direct`=1, `offset` is the extended displacement alone, `seg_stack`=0 and `idx_err`=0. The base and index inputs are ignored.
- R6: With `direct`=0 and no error, `offset` is the sum of three terms:
  - the base value, only when `base_en`=1;
  - the scaled index, only when `idx_en`=1;
  - the extended displacement.
- R7: Scale code s (0..3) shifts the index left by s bits, which multiplies it by 1, 2, 4 or 8.
- R8: With `direct`=0, `seg_stack` is 1 exactly when `base_en`=1 and `base_num` is 4 or 5. A missing base or any other base selects the data segment (0).
- R9: With `direct`=0, `idx_en`=1 and `idx_num`=4, `idx_err` is 1, `offset` is 0 and `seg_stack` is 0.
- R10: The sum wraps modulo 2^32, and the carry out is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that loads the operands |
| direct | input | 1 | Direct addressing: displacement only |
| base_en | input | 1 | Base register present |
| base_num | input | 3 | Base register number |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index register present |
| idx_num | input | 3 | Index register number |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Scale code, shift of 0..3 |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 32 | Raw displacement |
| out_valid | output | 1 | Result presented this cycle |
| offset | output | 32 | Computed operand offset |
| seg_stack | output | 1 | 1: stack segment default, 0: data segment |
| idx_err | output | 1 | Stack pointer used as index |

## Verification
The bench builds the block with its default parameters: a 32-bit offset, 3-bit register numbers, and the stack and frame pointers at numbers 4 and 5. With 3-bit numbers, random picks hit the stack pointer as base or index about one time in eight, so the error path and the stack-segment path are both exercised often. With a 32-bit width, directed operands near 2^32 reach the wrap of the sum. Both negative 8-bit displacements and 16-bit displacements with the high bit set are driven, which tells sign extension apart from zero extension.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_BYTE = 2'd1,
        DSZ_HALF = 2'd2,
        DSZ_FULL = 2'd3
    } dsz_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ea_state_t;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int W = 32
) (
    input  logic [1:0]   sz,
    input  logic [W-1:0] raw,
    output logic [W-1:0] ext
);
    import ea_pkg::*;

    always_comb begin
        unique case (dsz_t'(sz))
            DSZ_NONE: ext = '0;
            DSZ_BYTE: ext = {{(W-8){raw[7]}}, raw[7:0]};
            DSZ_HALF: ext = {{(W-16){1'b0}}, raw[15:0]};
            DSZ_FULL: ext = raw;
            default:  ext = '0;
        endcase
    end
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
    parameter int W      = 32,
    parameter int NUM_W  = 3,
    parameter int SP_NUM = 4
) (
    input  logic             en,
    input  logic [NUM_W-1:0] num,
    input  logic [W-1:0]     val,
    input  logic [1:0]       scale,
    output logic [W-1:0]     scaled,
    output logic             illegal
);
    localparam int NSCALE = 4;

    logic [W-1:0] shifted [NSCALE];

    for (genvar s = 0; s < NSCALE; s++) begin : g_shift
        assign shifted[s] = val << s;
    end

    assign scaled  = en ? shifted[scale] : '0;
    assign illegal = en && (num == NUM_W'(SP_NUM));
endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select #(
    parameter int NUM_W  = 3,
    parameter int SP_NUM = 4,
    parameter int FP_NUM = 5
) (
    input  logic             direct,
    input  logic             base_en,
    input  logic [NUM_W-1:0] base_num,
    output logic             stack
);
    logic stack_base;

    assign stack_base = (base_num == NUM_W'(SP_NUM)) || (base_num == NUM_W'(FP_NUM));
    assign stack      = !direct && base_en && stack_base;
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int W      = 32,
    parameter int NUM_W  = 3,
    parameter int SP_NUM = 4,
    parameter int FP_NUM = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             direct,
    input  logic             base_en,
    input  logic [NUM_W-1:0] base_num,
    input  logic [W-1:0]     base_val,
    input  logic             idx_en,
    input  logic [NUM_W-1:0] idx_num,
    input  logic [W-1:0]     idx_val,
    input  logic [1:0]       scale,
    input  logic [1:0]       disp_sz,
    input  logic [W-1:0]     disp,
    output logic             out_valid,
    output logic [W-1:0]     offset,
    output logic             seg_stack,
    output logic             idx_err
);
    import ea_pkg::*;

    ea_state_t    state_q, state_d;
    logic [W-1:0] disp_ext, idx_scaled, base_term, sum;
    logic         idx_bad, stack_sel, err_now;

    ea_disp_ext #(.W(W)) u_disp (
        .sz  (disp_sz),
        .raw (disp),
        .ext (disp_ext)
    );

    ea_index_scale #(.W(W), .NUM_W(NUM_W), .SP_NUM(SP_NUM)) u_idx (
        .en      (idx_en && !direct),
        .num     (idx_num),
        .val     (idx_val),
        .scale   (scale),
        .scaled  (idx_scaled),
        .illegal (idx_bad)
    );

    ea_seg_select #(.NUM_W(NUM_W), .SP_NUM(SP_NUM), .FP_NUM(FP_NUM)) u_seg (
        .direct   (direct),
        .base_en  (base_en),
        .base_num (base_num),
        .stack    (stack_sel)
    );

    assign base_term = (base_en && !direct) ? base_val : '0;
    assign sum       = base_term + idx_scaled + disp_ext;
    assign err_now   = idx_bad;

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset    <= '0;
            seg_stack <= 1'b0;
            idx_err   <= 1'b0;
        end else if (in_valid) begin
            offset    <= err_now ? '0 : sum;
            seg_stack <= err_now ? 1'b0 : stack_sel;
            idx_err   <= err_now;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(offset) && $stable(seg_stack) && $stable(idx_err)));
    // R5
    direct_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && direct) |=> (!seg_stack && !idx_err));
    // R9
    idx_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |-> (offset == '0 && !seg_stack));
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, direct, base_en, idx_en;
    logic [2:0]  base_num, idx_num;
    logic [31:0] base_val, idx_val, disp;
    logic [1:0]  scale, disp_sz;
    logic        out_valid, seg_stack, idx_err;
    logic [31:0] offset;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ea_gen u_ea_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .direct(direct),
        .base_en(base_en), .base_num(base_num), .base_val(base_val),
        .idx_en(idx_en), .idx_num(idx_num), .idx_val(idx_val),
        .scale(scale), .disp_sz(disp_sz), .disp(disp),
        .out_valid(out_valid), .offset(offset),
        .seg_stack(seg_stack), .idx_err(idx_err)
    );

    function automatic logic [31:0] ext_of(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0:    return 32'd0;
            2'd1:    return {{24{d[7]}}, d[7:0]};
            2'd2:    return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive one strobe, then sample at the next negedge.
    task automatic apply(input string tag, input bit dir, input bit be, input logic [2:0] bn,
                         input logic [31:0] bv, input bit ie, input logic [2:0] inum,
                         input logic [31:0] iv, input logic [1:0] sc,
                         input logic [1:0] dsz, input logic [31:0] d);
        logic [31:0] e_off;
        logic        e_stk, e_err;
        in_valid = 1; direct = dir; base_en = be; base_num = bn; base_val = bv;
        idx_en = ie; idx_num = inum; idx_val = iv; scale = sc; disp_sz = dsz; disp = d;
        if (dir) begin
            e_off = ext_of(dsz, d); e_stk = 0; e_err = 0;
        end else if (ie && inum == 3'd4) begin
            e_off = 0; e_stk = 0; e_err = 1;
        end else begin
            e_off = (be ? bv : 32'd0) + (ie ? (iv << sc) : 32'd0) + ext_of(dsz, d);
            e_stk = be && (bn == 3'd4 || bn == 3'd5);
            e_err = 0;
        end
        @(negedge clk);
        in_valid = 0;
        check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " offset"}, offset, e_off);
        check({tag, " R8 seg"}, {31'd0, seg_stack}, {31'd0, e_stk});
        check({tag, " R9 err"}, {31'd0, idx_err}, {31'd0, e_err});
    endtask

    // R3: no strobe, scrambled inputs; outputs must hold, out_valid low.
    task automatic idle_check();
        logic [31:0] p_off;
        logic        p_stk, p_err;
        p_off = offset; p_stk = seg_stack; p_err = idx_err;
        in_valid = 0; direct = $urandom; base_en = 1; base_num = 3'd4;
        base_val = $urandom; idx_en = 1; idx_num = $urandom; idx_val = $urandom;
        disp_sz = 2'd3; disp = $urandom;
        @(negedge clk);
        check("R2 valid low", {31'd0, out_valid}, 32'd0);
        check("R3 hold offset", offset, p_off);
        check("R3 hold flags", {30'd0, seg_stack, idx_err}, {30'd0, p_stk, p_err});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; in_valid = 0; direct = 0; base_en = 0; idx_en = 0;
        base_num = 0; idx_num = 0; base_val = 0; idx_val = 0;
        scale = 0; disp_sz = 0; disp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset offset", offset, 32'd0);
        check("R1 reset flags", {30'd0, seg_stack, idx_err}, 32'd0);

        // R4 displacement sizes
        apply("R4 none", 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 32'hFFFF_FFFF);
        apply("R4 byte neg", 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 32'h1234_5680);
        apply("R4 half hi", 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'hABCD_8001);
        apply("R4 full", 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 32'hDEAD_BEEF);
        // R5 direct ignores base and index, even the stack pointer index
        apply("R5 direct", 1, 1, 3'd4, 32'h1111, 1, 3'd4, 32'h2222, 2'd3, 2'd2, 32'h0000_F00D);
        // R7 each scale
        for (int s = 0; s < 4; s++)
            apply("R7 scale", 0, 0, 0, 0, 1, 3'd1, 32'h0000_0013, s[1:0], 2'd1, 32'h0000_0004);
        // R8 stack/frame/other bases
        apply("R8 sp base", 0, 1, 3'd4, 32'h100, 0, 0, 0, 0, 2'd0, 0);
        apply("R8 fp base", 0, 1, 3'd5, 32'h200, 1, 3'd0, 32'h8, 2'd2, 2'd1, 32'hF0);
        apply("R8 other base", 0, 1, 3'd3, 32'h300, 0, 0, 0, 0, 2'd0, 0);
        // R9 illegal index
        apply("R9 sp index", 0, 1, 3'd5, 32'h400, 1, 3'd4, 32'h10, 2'd1, 2'd3, 32'h5);
        idle_check();
        // R10 wrap
        apply("R10 wrap", 0, 1, 3'd0, 32'hFFFF_FFF0, 1, 3'd2, 32'h8000_0008, 2'd1, 2'd1, 32'h20);
        // R6 all three terms
        apply("R6 full form", 0, 1, 3'd6, 32'h0001_0000, 1, 3'd7, 32'h0000_0100, 2'd3, 2'd3, 32'h0000_0020);

        for (int i = 0; i < 400; i++) begin
            string t;
            logic  dr;
            logic  be, ie;
            logic [2:0] bn, inum;
            dr = ($urandom % 6) == 0;
            be = $urandom; ie = $urandom; bn = $urandom; inum = $urandom;
            t = dr ? "R5 rand" : ((ie && inum == 3'd4) ? "R9 rand" : "R6 rand");
            apply(t, dr, be, bn, $urandom, ie, inum, $urandom, 2'($urandom),
                  2'($urandom), $urandom);
            if (($urandom % 5) == 0) idle_check();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule